// File: doc/BRIEF.md
# I2C Master Start-Condition Generator

This block produces the opening Start condition of an I2C transfer for a bus master. A one-cycle request pulse starts the sequence, but only when both bus lines are seen high. An 8-bit reload value paces the sequence through a down-counting baud timer. When the first timer period ends and both lines are still high, the block pulls SDA low while SCL stays released, which forms the Start condition. It then lets a second period pass and finishes. At that point SDA is still held low, and the logic that sends the address can take over.

The block has two open-drain drive enables. A 1 on an enable pulls its line low, and a 0 releases it. The bus lines are read back through a two-flop synchronizer. If a line is seen low when it should be high, the attempt counts as a bus collision. The block drops the attempt, releases both lines and raises a collision flag. Success and collision each have their own flag. A flag stays set until its own clear strobe is pulsed.

Top module: `i2c_start_gen`

## Requirements
- R1: While reset is active and right after it, the outputs `sda_drv`, `scl_drv`, `start_en`, `start_seen`, `done_irq` and `col_irq` are all 0.
- R2: A request taken at clock edge T, with both synchronized lines high, sets `start_en` at edge T. `sda_drv` then rises at edge T+reload+1, and `scl_drv` stays 0 the whole time.
- R3: `start_seen` becomes 1 at the same edge at which `sda_drv` rises.
- R4: At edge T+2*(reload+1), `start_en` clears and `done_irq` sets. After that, `sda_drv` stays 1 until reset.
- R5: A reload value of 0 gives a period of one clock: `sda_drv` rises at T+1 and `done_irq` sets at T+2.
- R6: A request taken while either synchronized line is low sets `col_irq` at edge T. `start_en` and `sda_drv` stay 0, and a later request with both lines high runs normally.
- R7: A collision aborts a running sequence at the edge it is detected. The causes are SCL seen low at any point before SDA is driven, or SDA seen low when the first period ends. On abort, `col_irq` sets and `start_en`, `sda_drv` and `start_seen` clear.
- R8: A request that arrives while a sequence runs, or after it has completed, is ignored. The timing does not change, no new flag is set and the line drives stay as they were.
- R9: Each flag stays set until its own clear strobe is pulsed (`clr_done`, `clr_col`). If a set and a clear fall in the same cycle, the set wins.
- R10: Each bus input passes through two synchronizer flops. A line that drops at the same time a request is raised does not block the request. It is seen two edges later, as a collision during the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to begin a Start |
| reload | input | RELOAD_W | Baud timer reload value (period = reload+1 clocks) |
| clr_done | input | 1 | Clear strobe for the completion flag |
| clr_col | input | 1 | Clear strobe for the collision flag |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| sda_drv | output | 1 | SDA pull-low enable |
| scl_drv | output | 1 | SCL pull-low enable (held released here) |
| start_en | output | 1 | Sequence in progress; cleared by hardware |
| start_seen | output | 1 | Start condition has been placed on the bus |
| done_irq | output | 1 | Sticky completion flag |
| col_irq | output | 1 | Sticky bus-collision flag |

## Verification
A flag can be set by the sequencer in the same cycle that software pulses its clear strobe. The bench creates this clash in two places. It raises `clr_done` on the negative edge just before the calculated completion edge, and it raises `clr_col` together with a request made while SCL is low. In both cases the flag must read 1 afterwards and read 0 only after a separate, later clear pulse. A scoreboard predicts the exact edge of every rising SDA drive, completion and collision, so any event that comes early, late or without being predicted is reported.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_HELD = 2'd3
    } stg_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    localparam int NUM_LINES = 2;
    localparam int NUM_FLAGS = 2;

    function automatic logic both_high(input line_t l);
        return l.sda & l.scl;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/i2cs_brg.sv
module i2cs_brg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic         tout
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= reload;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign tout = (cnt == '0);
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
    import i2cs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_req,
    input  line_t ln,
    input  logic  tout,
    output logic  load,
    output logic  run,
    output logic  sda_drv,
    output logic  start_en,
    output logic  start_seen,
    output logic  set_done,
    output logic  set_col
);
    stg_e st, nxt;

    always_comb begin
        nxt      = st;
        load     = 1'b0;
        set_done = 1'b0;
        set_col  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_req) begin
                    if (both_high(ln)) begin
                        load = 1'b1;
                        nxt  = ST_PRE;
                    end else begin
                        set_col = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (!ln.scl) begin
                    set_col = 1'b1;
                    nxt     = ST_IDLE;
                end else if (tout) begin
                    if (ln.sda) begin
                        load = 1'b1;
                        nxt  = ST_POST;
                    end else begin
                        set_col = 1'b1;
                        nxt     = ST_IDLE;
                    end
                end
            end
            ST_POST: begin
                if (tout) begin
                    set_done = 1'b1;
                    nxt      = ST_HELD;
                end
            end
            default: nxt = ST_HELD;
        endcase
    end

    assign run = (st == ST_PRE) || (st == ST_POST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            sda_drv    <= 1'b0;
            start_en   <= 1'b0;
            start_seen <= 1'b0;
        end else begin
            st         <= nxt;
            sda_drv    <= (nxt == ST_POST) || (nxt == ST_HELD);
            start_en   <= (nxt == ST_PRE)  || (nxt == ST_POST);
            start_seen <= (nxt == ST_POST) || (nxt == ST_HELD);
        end
    end
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
    import i2cs_pkg::*;
#(
    parameter int RELOAD_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_req,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                clr_done,
    input  logic                clr_col,
    input  logic                sda_in,
    input  logic                scl_in,
    output logic                sda_drv,
    output logic                scl_drv,
    output logic                start_en,
    output logic                start_seen,
    output logic                done_irq,
    output logic                col_irq
);
    logic [NUM_LINES-1:0] raw, syn;
    line_t                ln;
    logic                 sda_s, scl_s;
    logic                 load, run, tout, set_done, set_col;
    logic [NUM_FLAGS-1:0] fset, fclr, fq;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
        i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[g]),
            .q   (syn[g])
        );
    end

    assign sda_s  = syn[0];
    assign scl_s  = syn[1];
    assign ln.sda = sda_s;
    assign ln.scl = scl_s;

    i2cs_brg #(.W(RELOAD_W)) u_brg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .run    (run),
        .reload (reload),
        .tout   (tout)
    );

    i2cs_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .ln         (ln),
        .tout       (tout),
        .load       (load),
        .run        (run),
        .sda_drv    (sda_drv),
        .start_en   (start_en),
        .start_seen (start_seen),
        .set_done   (set_done),
        .set_col    (set_col)
    );

    assign fset = {set_col, set_done};
    assign fclr = {clr_col, clr_done};

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)          fq[f] <= 1'b0;
            else if (fset[f]) fq[f] <= 1'b1;
            else if (fclr[f]) fq[f] <= 1'b0;
        end
    end

    assign done_irq = fq[0];
    assign col_irq  = fq[1];
    assign scl_drv  = 1'b0;
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk (
    input logic clk,
    input logic rst,
    input logic clr_done,
    input logic clr_col,
    input logic sda_s,
    input logic scl_s,
    input logic sda_drv,
    input logic start_en,
    input logic start_seen,
    input logic done_irq,
    input logic col_irq
);
    AST_SDA_FALL_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drv) |-> $past(sda_s && scl_s)); // R2

    AST_SEEN_WITH_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(start_seen) |-> (sda_drv && start_en)); // R3

    AST_DONE_KEEPS_SDA: assert property (@(posedge clk) disable iff (rst)
        $rose(done_irq) |-> (sda_drv && !start_en)); // R4

    AST_EN_DROP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        $fell(start_en) |-> (done_irq || col_irq)); // R4

    AST_COL_RELEASES: assert property (@(posedge clk) disable iff (rst)
        $rose(col_irq) |-> (!sda_drv && !start_en && !start_seen)); // R7

    AST_HELD_STAYS: assert property (@(posedge clk) disable iff (rst)
        (sda_drv && !start_en) |=> (sda_drv && !start_en)); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done_irq && !clr_done) |=> done_irq); // R9

    AST_COL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (col_irq && !clr_col) |=> col_irq); // R9
endmodule

bind i2c_start_gen i2c_start_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_done   (clr_done),
    .clr_col    (clr_col),
    .sda_s      (sda_s),
    .scl_s      (scl_s),
    .sda_drv    (sda_drv),
    .start_en   (start_en),
    .start_seen (start_seen),
    .done_irq   (done_irq),
    .col_irq    (col_irq)
);

// File: tb/tb_i2c_start_gen.sv
`timescale 1ns/1ps
module tb_i2c_start_gen;
    localparam int W = 8;
    localparam int EV_SDA = 0, EV_DONE = 1, EV_COL = 2;

    logic clk = 0, rst = 1, start_req = 0, clr_done = 0, clr_col = 0;
    logic [W-1:0] reload = '0;
    logic sda_ext = 1, scl_ext = 1;
    logic sda_in, scl_in, sda_drv, scl_drv, start_en, start_seen, done_irq, col_irq;

    assign sda_in = sda_ext & ~sda_drv;
    assign scl_in = scl_ext & ~scl_drv;

    i2c_start_gen #(.RELOAD_W(W)) dut (
        .clk(clk), .rst(rst), .start_req(start_req), .reload(reload),
        .clr_done(clr_done), .clr_col(clr_col), .sda_in(sda_in), .scl_in(scl_in),
        .sda_drv(sda_drv), .scl_drv(scl_drv), .start_en(start_en),
        .start_seen(start_seen), .done_irq(done_irq), .col_irq(col_irq)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;

    typedef struct { int kind; int at; string tag; } exp_t;
    exp_t q[$];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic push(input int kind, input int at, input string tag);
        exp_t e;
        e.kind = kind; e.at = at; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic seen(input int kind);
        exp_t e;
        if (q.size() == 0) begin
            check(0, "unexpected event (R8)", kind, -1);
        end else begin
            e = q.pop_front();
            check(e.kind == kind, {e.tag, " event kind"}, kind, e.kind);
            check(e.at == cyc, {e.tag, " event cycle"}, cyc, e.at);
        end
    endtask

    // monitor: compares observed rising events against the scoreboard
    logic p_sda = 0, p_done = 0, p_col = 0;
    always @(negedge clk) begin
        if (rst) begin
            p_sda = 0; p_done = 0; p_col = 0;
        end else begin
            if (sda_drv && !p_sda) begin
                seen(EV_SDA);
                check(start_seen == 1'b1, "R3 start_seen with SDA drive", start_seen, 1);
                check(scl_drv == 1'b0, "R2 SCL released", scl_drv, 0);
            end
            if (done_irq && !p_done) seen(EV_DONE);
            if (col_irq && !p_col)   seen(EV_COL);
            p_sda = sda_drv; p_done = done_irq; p_col = col_irq;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired (R1..) actual=%0d expected=0", cyc);
        summary();
        $finish;
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1; start_req = 0; clr_done = 0; clr_col = 0;
        sda_ext = 1; scl_ext = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // raise the request at the current negedge; t is the accepting edge
    task automatic launch(output int t);
        start_req = 1;
        t = cyc + 1;
    endtask

    task automatic pulse_clr_done();
        clr_done = 1; @(negedge clk); clr_done = 0;
    endtask

    task automatic pulse_clr_col();
        clr_col = 1; @(negedge clk); clr_col = 0;
    endtask

    initial begin
        int t, m;
        // R1 reset state
        do_reset();
        check({sda_drv, scl_drv, start_en, start_seen, done_irq, col_irq} == 6'b0,
              "R1 outputs after reset", {sda_drv, scl_drv, start_en, start_seen, done_irq, col_irq}, 0);

        // R2 R3 R4 R8 R9 normal start, reload 5
        reload = 8'd5;
        launch(t);
        push(EV_SDA, t + 6, "R2 SDA low");
        push(EV_DONE, t + 12, "R4 done");
        @(negedge clk); start_req = 0;
        check(start_en == 1'b1, "R2 start_en set", start_en, 1);
        wait_until(t + 3);
        start_req = 1;                        // R8 busy request
        @(negedge clk); start_req = 0;
        wait_until(t + 14);
        check(start_en == 1'b0, "R4 start_en cleared", start_en, 0);
        check(sda_drv == 1'b1, "R4 SDA held", sda_drv, 1);
        repeat (6) @(negedge clk);
        check(done_irq == 1'b1, "R9 done sticky", done_irq, 1);
        start_req = 1;                        // R8 request after completion
        @(negedge clk); start_req = 0;
        repeat (8) @(negedge clk);
        check(start_en == 1'b0, "R8 no restart", start_en, 0);
        check(sda_drv == 1'b1, "R8 SDA still held", sda_drv, 1);
        pulse_clr_done();
        check(done_irq == 1'b0, "R9 done cleared", done_irq, 0);

        // R5 reload zero
        do_reset();
        reload = 8'd0;
        launch(t);
        push(EV_SDA, t + 1, "R5 SDA low");
        push(EV_DONE, t + 2, "R5 done");
        @(negedge clk); start_req = 0;
        wait_until(t + 4);
        check(done_irq == 1'b1, "R5 done set", done_irq, 1);

        // R9 set and clear in the same cycle
        do_reset();
        reload = 8'd3;
        launch(t);
        push(EV_SDA, t + 4, "R2 SDA low r3");
        push(EV_DONE, t + 8, "R9 done vs clear");
        @(negedge clk); start_req = 0;
        wait_until(t + 7);
        clr_done = 1;
        @(negedge clk); clr_done = 0;
        check(done_irq == 1'b1, "R9 set wins over clear", done_irq, 1);
        pulse_clr_done();
        check(done_irq == 1'b0, "R9 later clear", done_irq, 0);

        // R6 collision at request: SCL low, with clear in same cycle
        do_reset();
        scl_ext = 0;
        repeat (4) @(negedge clk);
        reload = 8'd2;
        launch(t);
        clr_col = 1;
        push(EV_COL, t, "R6 SCL low at request");
        @(negedge clk); start_req = 0; clr_col = 0;
        check(col_irq == 1'b1, "R9 col set wins", col_irq, 1);
        check(start_en == 1'b0, "R6 no start", start_en, 0);
        check(sda_drv == 1'b0, "R6 SDA released", sda_drv, 0);
        scl_ext = 1; sda_ext = 0;
        pulse_clr_col();
        check(col_irq == 1'b0, "R9 col cleared", col_irq, 0);
        repeat (4) @(negedge clk);
        launch(t);
        push(EV_COL, t, "R6 SDA low at request");
        @(negedge clk); start_req = 0;
        check(start_en == 1'b0, "R6 no start on SDA low", start_en, 0);
        sda_ext = 1;
        pulse_clr_col();
        repeat (4) @(negedge clk);
        launch(t);
        push(EV_SDA, t + 3, "R6 retry SDA low");
        push(EV_DONE, t + 6, "R6 retry done");
        @(negedge clk); start_req = 0;
        wait_until(t + 7);
        check(done_irq == 1'b1, "R6 retry completes", done_irq, 1);

        // R7 SCL drops during first period
        do_reset();
        reload = 8'd20;
        launch(t);
        @(negedge clk); start_req = 0;
        wait_until(t + 4);
        scl_ext = 0; m = cyc;
        push(EV_COL, m + 3, "R7 SCL low mid-sequence");
        wait_until(m + 4);
        check(start_en == 1'b0, "R7 start_en cleared", start_en, 0);
        check(sda_drv == 1'b0, "R7 SDA released", sda_drv, 0);
        check(start_seen == 1'b0, "R7 start_seen clear", start_seen, 0);
        scl_ext = 1;

        // R7 SDA low at first timeout
        do_reset();
        reload = 8'd10;
        launch(t);
        @(negedge clk); start_req = 0;
        wait_until(t + 2);
        sda_ext = 0;
        push(EV_COL, t + 11, "R7 SDA low at timeout");
        wait_until(t + 12);
        check(start_en == 1'b0, "R7 aborted at timeout", start_en, 0);
        sda_ext = 1;

        // R10 line drop coincident with request is seen two edges later
        do_reset();
        reload = 8'd10;
        m = cyc;
        scl_ext = 0;
        launch(t);
        push(EV_COL, m + 3, "R10 synchronized collision");
        @(negedge clk); start_req = 0;
        check(start_en == 1'b1, "R10 request accepted", start_en, 1);
        wait_until(m + 4);
        check(col_irq == 1'b1, "R10 collision flagged", col_irq, 1);
        scl_ext = 1;

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R2 scoreboard drained", q.size(), 0);
        summary();
        $finish;
    end
endmodule